// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Combiner

This block gathers thirty-two interrupt request lines into a single interrupt output. Each line is given its own trigger style through two bit-planes, a trigger-mode plane and a trigger-polarity plane. Edge-triggered lines latch a pending flag that software clears by writing a one to it. Level-triggered lines show the live, synchronised state of their input. A mask plane selects which pending flags may reach the combined output.

The combined line also has a programmable style. It can act as a level that is active high or active low, or it can send a one-cycle pulse of either polarity whenever the masked request set goes from empty to non-empty. A write-only inject register lets test software set pending flags without driving the input pins.

Software reaches the block over a plain word-wide register port that has an address, a write strobe, write data and combinational read data. Bits [1:0] of the address are ignored. The reset is asynchronous and active low, and the surrounding logic must release it synchronously.

Top module: `trig_irq_combiner`

## Requirements
- R1: The word registers are mask 0x00, pending 0x04, trigger mode 0x08, trigger polarity 0x0C, output mode 0x10, output polarity 0x14 and inject 0x18. The mask, trigger-mode and trigger-polarity registers read back all 32 written bits. The output-mode and output-polarity registers keep only bit 0 and read back zero-extended. Any other offset reads zero.
- R2: While reset is asserted, every register reads zero and `irq_out` is 1.
- R3: A line with {mode,polarity} = {1,1} sets its pending bit on a 0-to-1 transition of its input. The bit becomes readable three clock edges after the input changes.
- R4: A line with {mode,polarity} = {1,0} sets its pending bit on a 1-to-0 transition of its input.
- R5: A line with {mode,polarity} = {0,1} shows a pending bit equal to its synchronised input. Writing 1 to that pending bit has no effect.
- R6: A line with {mode,polarity} = {0,0} shows a pending bit equal to the inverse of its synchronised input.
- R7: An edge line's pending bit stays set until a write to 0x04 has a 1 in that bit position. Written 0 bits leave their bits unchanged, and writing all ones clears every edge bit at once.
- R8: Writing 1 to a bit of 0x18 sets the matching pending bit. Reading 0x18 returns zero.
- R9: The combined request is the OR of (pending AND mask). When that AND is zero, the output stays deasserted.
- R10: With output mode 0, `irq_out` is a level, registered one cycle after the combined request. Polarity 0 makes it active low and polarity 1 makes it active high.
- R11: With output mode 1, `irq_out` sends exactly one asserted cycle each time the combined request rises. Polarity 1 gives a high pulse with the line idling low. Polarity 0 gives a low pulse with the line idling high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | N_SRC (32) | Write data |
| bus_rdata | output | N_SRC (32) | Combinational read data for `bus_addr` |
| src_in | input | N_SRC (32) | Asynchronous interrupt request lines |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The assertions assume that the write strobe and the inject data are inactive while reset is asserted. They also assume that `bus_addr` is stable around the sampling edge. The single-pulse checks on the output count only cycles in which the output style was already unchanged on the cycle before. The bench therefore drives every input on the falling clock edge and holds each source pattern for four cycles, so every transition passes through the synchroniser. After changing a trigger style it waits for the synchroniser to settle and then clears all pending bits before it begins judging results.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    RI_MASK   = 3'd0,
    RI_PEND   = 3'd1,
    RI_TMODE  = 3'd2,
    RI_TPOL   = 3'd3,
    RI_OMODE  = 3'd4,
    RI_OPOL   = 3'd5,
    RI_INJECT = 3'd6,
    RI_NONE   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_nxt;

  always_comb begin
    stg_nxt[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_nxt[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] inject_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise, fall, evt, lvl;
    assign rise = sync_i[b] & ~prev_q[b];
    assign fall = ~sync_i[b] & prev_q[b];
    assign evt  = pol_i[b] ? rise : fall;
    assign lvl  = ~(sync_i[b] ^ pol_i[b]);
    assign pend_nxt[b] = mode_i[b]
                       ? ((pend_q[b] & ~ack_i[b]) | evt | inject_i[b])
                       : (lvl | inject_i[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_nxt;
    end
  end

  assign pend_o = pend_q;

  // R7: an edge bit that was set and not acknowledged remains set
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend_q & mode_i & ~ack_i) & ~pend_q) == '0));

  // R8: an injected bit is pending on the following cycle
  p_inject_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(inject_i) & ~pend_q) == '0));

  // R5: an inactive level line without injection is not pending
  p_level_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(~mode_i & ~inject_i & (sync_i ^ pol_i)) & pend_q) == '0));
endmodule

// File: rtl/irqc_outdrv.sv
module irqc_outdrv (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic mode_i,
  input  logic pol_i,
  output logic irq_o
);
  logic req_d_q;
  logic irq_q;
  logic active;
  logic irq_nxt;

  always_comb begin
    active  = mode_i ? (req_i & ~req_d_q) : req_i;
    irq_nxt = pol_i ? active : ~active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      req_d_q <= req_i;
      irq_q   <= irq_nxt;
    end
  end

  assign irq_o = irq_q;

  // R10: active-low level output idles high when nothing is requested
  p_low_level_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !pol_i && !req_i) |=> irq_o);

  // R11: a high pulse in edge mode lasts a single cycle
  p_high_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && pol_i && $past(mode_i && pol_i) && irq_o) |=> !irq_o);

  // R11: a low pulse in edge mode lasts a single cycle
  p_low_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !pol_i && $past(mode_i && !pol_i) && !irq_o) |=> irq_o);
endmodule

// File: rtl/trig_irq_combiner.sv
module trig_irq_combiner #(
  parameter int unsigned N_SRC     = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              irq_out
);
  import irqc_pkg::*;

  localparam int unsigned IDX_LSB = 2;

  logic [N_SRC-1:0] mask_q, tmode_q, tpol_q;
  logic [N_SRC-1:0] mask_nxt, tmode_nxt, tpol_nxt;
  logic             omode_q, opol_q, omode_nxt, opol_nxt;
  logic [N_SRC-1:0] src_sync, pend, ack, inject;
  logic             hi_zero;
  reg_idx_e         idx;
  logic             req_any;

  // address decode
  assign hi_zero = ((bus_addr >> (IDX_LSB + IDX_W)) == '0);
  always_comb begin
    idx = RI_NONE;
    if (hi_zero) idx = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  end

  // next state of the configuration registers
  always_comb begin
    mask_nxt  = mask_q;
    tmode_nxt = tmode_q;
    tpol_nxt  = tpol_q;
    omode_nxt = omode_q;
    opol_nxt  = opol_q;
    if (bus_we) begin
      case (idx)
        RI_MASK:  mask_nxt  = bus_wdata;
        RI_TMODE: tmode_nxt = bus_wdata;
        RI_TPOL:  tpol_nxt  = bus_wdata;
        RI_OMODE: omode_nxt = bus_wdata[0];
        RI_OPOL:  opol_nxt  = bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      tmode_q <= '0;
      tpol_q  <= '0;
      omode_q <= 1'b0;
      opol_q  <= 1'b0;
    end else if (bus_we) begin
      mask_q  <= mask_nxt;
      tmode_q <= tmode_nxt;
      tpol_q  <= tpol_nxt;
      omode_q <= omode_nxt;
      opol_q  <= opol_nxt;
    end
  end

  // one-cycle strobes toward the pending plane
  assign ack    = (bus_we && idx == RI_PEND)   ? bus_wdata : '0;
  assign inject = (bus_we && idx == RI_INJECT) ? bus_wdata : '0;

  irqc_sync #(.W(N_SRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_in),
    .q_o   (src_sync)
  );

  irqc_pending #(.W(N_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (src_sync),
    .mode_i   (tmode_q),
    .pol_i    (tpol_q),
    .ack_i    (ack),
    .inject_i (inject),
    .pend_o   (pend)
  );

  assign req_any = |(pend & mask_q);

  irqc_outdrv u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_any),
    .mode_i (omode_q),
    .pol_i  (opol_q),
    .irq_o  (irq_out)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (idx)
      RI_MASK:  bus_rdata = mask_q;
      RI_PEND:  bus_rdata = pend;
      RI_TMODE: bus_rdata = tmode_q;
      RI_TPOL:  bus_rdata = tpol_q;
      RI_OMODE: bus_rdata[0] = omode_q;
      RI_OPOL:  bus_rdata[0] = opol_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R8: the inject register never returns data
  p_inject_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == RI_INJECT) |-> (bus_rdata == '0));

  // R9: with everything masked the level output sits at its idle value
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !omode_q) |=> (irq_out == !$past(opol_q)));
endmodule

// File: tb/trig_irq_combiner_tb.sv
`timescale 1ns/1ps
module trig_irq_combiner_tb;
  logic        clk;
  logic        rst_n;
  logic [4:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] src;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [4:0] A_MASK = 5'h00, A_PEND = 5'h04, A_TMODE = 5'h08,
                         A_TPOL = 5'h0C, A_OMODE = 5'h10, A_OPOL = 5'h14,
                         A_INJ = 5'h18, A_HOLE = 5'h1C;

  trig_irq_combiner u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .src_in    (src),
    .irq_out   (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_level(input logic lvl, output int cnt);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (irq === lvl) cnt++;
    end
  endtask

  logic [31:0] r, m, p, v, prev, expe, rise, fall, lvl;
  string tag;
  int cnt;

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; src = '0;
    // R2: reset state
    rd(A_MASK, r);  chk("R2 mask", r, 0);
    rd(A_PEND, r);  chk("R2 pend", r, 0);
    rd(A_TMODE, r); chk("R2 tmode", r, 0);
    rd(A_TPOL, r);  chk("R2 tpol", r, 0);
    rd(A_OMODE, r); chk("R2 omode", r, 0);
    rd(A_OPOL, r);  chk("R2 opol", r, 0);
    chk("R2 irq", {31'b0, irq}, 1);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R1: readback and unmapped holes
    wr(A_MASK, 32'hA5C3_0F19);  rd(A_MASK, r);  chk("R1 mask", r, 32'hA5C3_0F19);
    wr(A_TMODE, 32'h1234_5678); rd(A_TMODE, r); chk("R1 tmode", r, 32'h1234_5678);
    wr(A_TPOL, 32'hFEDC_BA98);  rd(A_TPOL, r);  chk("R1 tpol", r, 32'hFEDC_BA98);
    wr(A_OMODE, 32'hFFFF_FFFF); rd(A_OMODE, r); chk("R1 omode", r, 32'h1);
    wr(A_OPOL, 32'hFFFF_FFFE);  rd(A_OPOL, r);  chk("R1 opol", r, 32'h0);
    rd(A_HOLE, r); chk("R1 hole", r, 0);
    wr(A_MASK, 0); wr(A_OMODE, 0); wr(A_OPOL, 0);

    // R3..R7: sweep of trigger styles over many input patterns
    for (int c = 0; c < 5; c++) begin
      case (c)
        0: begin m = '1; p = '1; tag = "R3"; end
        1: begin m = '1; p = '0; tag = "R4"; end
        2: begin m = '0; p = '1; tag = "R5"; end
        3: begin m = '0; p = '0; tag = "R6"; end
        default: begin m = 32'hA5A5_0F0F; p = 32'h3C3C_FF00; tag = "R7"; end
      endcase
      wr(A_TMODE, m); wr(A_TPOL, p); idle(4);
      wr(A_PEND, '1); idle(1);
      expe = '0; prev = src;
      for (int i = 0; i < 8; i++) begin
        v = i[0] ? ~src : (src ^ (32'h9E37_79B9 * (i + c * 8 + 1)));
        @(negedge clk); src = v;
        idle(4);
        rise = v & ~prev; fall = ~v & prev;
        expe = expe | (p & rise) | (~p & fall);
        prev = v;
        lvl = ~(v ^ p);
        rd(A_PEND, r); chk(tag, r, (m & expe) | (~m & lvl));
        if (i == 3) begin
          // R7 partial acknowledge, then a zero write; R5 level ignores it
          wr(A_PEND, 32'h0000_FFFF); expe = expe & 32'hFFFF_0000;
          wr(A_PEND, 32'h0);
          rd(A_PEND, r); chk({tag, " R7 ack"}, r, (m & expe) | (~m & lvl));
        end
      end
      wr(A_PEND, '1); expe = '0;
      rd(A_PEND, r); chk({tag, " R7 clear-all"}, r, ~m & lvl);
    end

    // R8: inject
    wr(A_TMODE, '1); wr(A_TPOL, '1); idle(4);
    wr(A_PEND, '1);
    wr(A_INJ, 32'h00F0_0001);
    rd(A_PEND, r); chk("R8 inject sets", r, 32'h00F0_0001);
    rd(A_INJ, r);  chk("R8 inject reads zero", r, 0);

    // R9/R10: masking and level output
    idle(2); chk("R9 all masked", {31'b0, irq}, 1);
    wr(A_MASK, 32'h0000_0100); idle(2);
    chk("R9 unpending bit unmasked", {31'b0, irq}, 1);
    wr(A_MASK, 32'h0000_0001); idle(2);
    chk("R10 active low", {31'b0, irq}, 0);
    wr(A_OPOL, 1); idle(2);
    chk("R10 active high", {31'b0, irq}, 1);
    wr(A_MASK, 0); idle(2);
    chk("R9 masked high polarity", {31'b0, irq}, 0);

    // R11: pulse outputs
    wr(A_OMODE, 1); idle(2);
    chk("R11 high pulse idle", {31'b0, irq}, 0);
    wr(A_MASK, 32'h0000_0001);
    count_level(1'b1, cnt);
    chk("R11 high pulse count", cnt, 1);
    wr(A_MASK, 0); wr(A_OPOL, 0); idle(2);
    chk("R11 low pulse idle", {31'b0, irq}, 1);
    wr(A_MASK, 32'h00F0_0000);
    count_level(1'b0, cnt);
    chk("R11 low pulse count", cnt, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule